// File: doc/BRIEF.md
# Synchronous and Debug Exception Dispatcher

This block sits beside a processor pipeline. It decides how the core enters an exception. The pipeline presents a synchronous fault with its cause code, the faulting PC and, for address faults, the faulting virtual address. It may also present a debug request with its own cause and PC. In the clock edge that accepts a request, the block updates its special registers and raises a one-cycle take strobe. Alongside the strobe it gives a vector-select code telling the fetch unit where to jump. It also holds the processor status word, and the pipeline may overwrite that word in any cycle in which no exception is taken.

The vector depends on the status word at the moment of the fault. A fault raised while the exception-mode bit is clear goes to the kernel vector, or to the user vector when the user-mode bit is set. A fault raised while exception mode is already set goes to the double-exception vector. Its PC is saved in a dedicated double-exception PC register when the `HAS_DEPC` parameter is 1, and in the level-1 PC register otherwise. A debug request enters at the configured debug level (`DBG_LEVEL`, 2 to 7), but only when the current interrupt level is below that level. The saved-PC and saved-status registers form arrays indexed by interrupt level.

The control is a small state machine whose state is the kind of dispatch taken at the last edge. `DS_IDLE` means nothing was taken. `DS_SYNC` is a first-level fault, `DS_DOUBLE` is a fault taken in exception mode, and `DS_DEBUG` is a debug entry. Every state may move to every other state at each edge. The next state is `DS_SYNC` or `DS_DOUBLE` when a fault is requested, chosen by the exception-mode bit. It is `DS_DEBUG` when only an allowed debug request is present, and `DS_IDLE` in every other case.

Top module: `exc_dispatch`

## Requirements
- R1: After reset the status word, all saved registers, the take strobe and the vector code are zero.
- R2: A fault with exception mode clear and user mode clear gives vector code 1 (kernel) and saves the PC into the level-1 PC register. Status bit 4 is exception mode and bit 5 is user mode.
- R3: A fault with exception mode clear and user mode set gives vector code 2 (user) and saves the PC into the level-1 PC register.
- R4: A fault with exception mode set gives vector code 3 (double). With `HAS_DEPC`=1 the PC goes to the double-exception PC register and the level-1 PC register is unchanged. With `HAS_DEPC`=0 the PC goes to the level-1 PC register.
- R5: Every taken fault writes the cause register and sets exception mode, and leaves the other status bits unchanged.
- R6: The faulting-address register is written only when a fault is taken with its address-valid input high. Otherwise it is unchanged.
- R7: A debug request is taken when status bits 3:0 (interrupt level) are below `DBG_LEVEL`. It gives vector code 4. It writes the debug-cause register, saves the debug PC and the old status word at index `DBG_LEVEL`, sets the interrupt level to `DBG_LEVEL` and sets exception mode.
- R8: A debug request with interrupt level at or above `DBG_LEVEL` is ignored: no strobe, and no register changes.
- R9: When a fault and a debug request arrive together, the fault is taken and the debug request is dropped.
- R10: A status write takes effect at the next edge when no exception is taken. It is discarded when an exception is taken in the same cycle.
- R11: The take strobe is high for exactly the cycle after each accepted request. The vector code is 0 whenever the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Synchronous fault request |
| exc_cause_i | input | CAUSE_W | Fault cause code |
| exc_pc_i | input | ADDR_W | PC of the faulting instruction |
| exc_addr_vld_i | input | 1 | Fault carries a virtual address |
| exc_addr_i | input | ADDR_W | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception request |
| dbg_cause_i | input | DCAUSE_W | Debug cause bits |
| dbg_pc_i | input | ADDR_W | PC for the debug entry |
| st_wr_i | input | 1 | Status word write enable |
| st_wdata_i | input | 8 | Status word write data |
| take_o | output | 1 | Exception taken strobe |
| vector_o | output | 3 | Vector code: 0 none, 1 kernel, 2 user, 3 double, 4 debug |
| status_o | output | 8 | Status word: bits 3:0 level, bit 4 exception mode, bit 5 user mode |
| cause_o | output | CAUSE_W | Cause register |
| vaddr_o | output | ADDR_W | Faulting-address register |
| epc1_o | output | ADDR_W | Level-1 exception PC |
| depc_o | output | ADDR_W | Double-exception PC (zero when not configured) |
| dbg_cause_o | output | DCAUSE_W | Debug cause register |
| dbg_epc_o | output | ADDR_W | Saved PC at the debug level |
| dbg_eps_o | output | 8 | Saved status word at the debug level |

## Verification
A wrong dispatch state appears at the ports in the very next cycle as a wrong vector code or a strobe. Because the vector is decoded from the state register, a state that is correct in kind but taken from a stale status word shows up as a user/kernel or double mix-up on that same strobe. A status word that is corrupted internally may stay hidden until the next fault or debug request. This is why every register is compared against the reference model on every clock, and why exception mode and the interrupt level are moved through all their combinations by status writes before each request.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;

    localparam int ST_W     = 8;
    localparam int IL_LSB   = 0;
    localparam int IL_W     = 4;
    localparam int EXCM_BIT = 4;
    localparam int UM_BIT   = 5;
    localparam int NLEV     = 7;

    typedef enum logic [2:0] {
        VEC_NONE   = 3'd0,
        VEC_KERNEL = 3'd1,
        VEC_USER   = 3'd2,
        VEC_DOUBLE = 3'd3,
        VEC_DEBUG  = 3'd4
    } vec_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_SYNC,
        DS_DOUBLE,
        DS_DEBUG
    } disp_state_e;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_dispatch_pkg::*;
#(
    parameter int DBG_LEVEL = 3
) (
    input  logic              exc_req,
    input  logic              dbg_req,
    input  logic              excm,
    input  logic [IL_W-1:0]   intlevel,
    output disp_state_e       next_state
);
    logic dbg_allowed;

    assign dbg_allowed = intlevel < IL_W'(DBG_LEVEL);

    // fault beats debug; debug beats idle
    always_comb begin
        if (exc_req) begin
            next_state = excm ? DS_DOUBLE : DS_SYNC;
        end else if (dbg_req && dbg_allowed) begin
            next_state = DS_DEBUG;
        end else begin
            next_state = DS_IDLE;
        end
    end
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
    import exc_dispatch_pkg::*;
#(
    parameter int DBG_LEVEL = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  disp_state_e       next_state,
    input  logic              wr_en,
    input  logic [ST_W-1:0]   wr_data,
    output logic [ST_W-1:0]   status_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            unique case (next_state)
                DS_SYNC, DS_DOUBLE: begin
                    status_q[EXCM_BIT] <= 1'b1;
                end
                DS_DEBUG: begin
                    status_q[IL_LSB +: IL_W] <= IL_W'(DBG_LEVEL);
                    status_q[EXCM_BIT]       <= 1'b1;
                end
                DS_IDLE: begin
                    if (wr_en) begin
                        status_q <= wr_data;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
    import exc_dispatch_pkg::*;
#(
    parameter int  DBG_LEVEL = 3,
    parameter bit  HAS_DEPC  = 1'b1,
    parameter int  ADDR_W    = 32,
    parameter int  CAUSE_W   = 6,
    parameter int  DCAUSE_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  disp_state_e          next_state,
    input  logic [ADDR_W-1:0]    exc_pc,
    input  logic [CAUSE_W-1:0]   exc_cause,
    input  logic                 addr_vld,
    input  logic [ADDR_W-1:0]    exc_addr,
    input  logic [ADDR_W-1:0]    dbg_pc,
    input  logic [DCAUSE_W-1:0]  dbg_cause,
    input  logic [ST_W-1:0]      old_status,
    output logic [CAUSE_W-1:0]   cause_q,
    output logic [ADDR_W-1:0]    vaddr_q,
    output logic [ADDR_W-1:0]    epc1_q,
    output logic [ADDR_W-1:0]    depc_q,
    output logic [DCAUSE_W-1:0]  dbg_cause_q,
    output logic [ADDR_W-1:0]    dbg_epc_q,
    output logic [ST_W-1:0]      dbg_eps_q
);
    logic [ADDR_W-1:0] epc_lv [1:NLEV];
    logic [ST_W-1:0]   eps_lv [2:NLEV];
    logic              fault_take;
    logic              lvl1_write;

    assign fault_take = (next_state == DS_SYNC) || (next_state == DS_DOUBLE);
    assign lvl1_write = (next_state == DS_SYNC) ||
                        ((next_state == DS_DOUBLE) && !HAS_DEPC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q     <= '0;
            vaddr_q     <= '0;
            dbg_cause_q <= '0;
        end else begin
            if (fault_take) begin
                cause_q <= exc_cause;
                if (addr_vld) begin
                    vaddr_q <= exc_addr;
                end
            end
            if (next_state == DS_DEBUG) begin
                dbg_cause_q <= dbg_cause;
            end
        end
    end

    // per-level saved PC / saved status arrays
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int lv = 1; lv <= NLEV; lv++) begin
                epc_lv[lv] <= '0;
            end
            for (int lv = 2; lv <= NLEV; lv++) begin
                eps_lv[lv] <= '0;
            end
        end else begin
            for (int lv = 1; lv <= NLEV; lv++) begin
                if (lv == 1 && lvl1_write) begin
                    epc_lv[lv] <= exc_pc;
                end else if (lv == DBG_LEVEL && next_state == DS_DEBUG) begin
                    epc_lv[lv] <= dbg_pc;
                end
            end
            for (int lv = 2; lv <= NLEV; lv++) begin
                if (lv == DBG_LEVEL && next_state == DS_DEBUG) begin
                    eps_lv[lv] <= old_status;
                end
            end
        end
    end

    generate
        if (HAS_DEPC) begin : g_depc
            logic [ADDR_W-1:0] depc_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    depc_r <= '0;
                end else if (next_state == DS_DOUBLE) begin
                    depc_r <= exc_pc;
                end
            end
            assign depc_q = depc_r;
        end else begin : g_no_depc
            assign depc_q = '0;
        end
    endgenerate

    assign epc1_q    = epc_lv[1];
    assign dbg_epc_q = epc_lv[DBG_LEVEL];
    assign dbg_eps_q = eps_lv[DBG_LEVEL];
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_dispatch_pkg::*;
#(
    parameter int DBG_LEVEL = 3,
    parameter bit HAS_DEPC  = 1'b1,
    parameter int ADDR_W    = 32,
    parameter int CAUSE_W   = 6,
    parameter int DCAUSE_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exc_req_i,
    input  logic [CAUSE_W-1:0]  exc_cause_i,
    input  logic [ADDR_W-1:0]   exc_pc_i,
    input  logic                exc_addr_vld_i,
    input  logic [ADDR_W-1:0]   exc_addr_i,
    input  logic                dbg_req_i,
    input  logic [DCAUSE_W-1:0] dbg_cause_i,
    input  logic [ADDR_W-1:0]   dbg_pc_i,
    input  logic                st_wr_i,
    input  logic [7:0]          st_wdata_i,
    output logic                take_o,
    output logic [2:0]          vector_o,
    output logic [7:0]          status_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic [ADDR_W-1:0]   vaddr_o,
    output logic [ADDR_W-1:0]   epc1_o,
    output logic [ADDR_W-1:0]   depc_o,
    output logic [DCAUSE_W-1:0] dbg_cause_o,
    output logic [ADDR_W-1:0]   dbg_epc_o,
    output logic [7:0]          dbg_eps_o
);
    disp_state_e       state_q;
    disp_state_e       state_d;
    logic [ST_W-1:0]   status_q;
    vec_e              vec;

    exc_arbiter #(.DBG_LEVEL(DBG_LEVEL)) u_arb (
        .exc_req    (exc_req_i),
        .dbg_req    (dbg_req_i),
        .excm       (status_q[EXCM_BIT]),
        .intlevel   (status_q[IL_LSB +: IL_W]),
        .next_state (state_d)
    );

    exc_status_reg #(.DBG_LEVEL(DBG_LEVEL)) u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_state (state_d),
        .wr_en      (st_wr_i),
        .wr_data    (st_wdata_i),
        .status_q   (status_q)
    );

    exc_save_bank #(
        .DBG_LEVEL (DBG_LEVEL),
        .HAS_DEPC  (HAS_DEPC),
        .ADDR_W    (ADDR_W),
        .CAUSE_W   (CAUSE_W),
        .DCAUSE_W  (DCAUSE_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .next_state  (state_d),
        .exc_pc      (exc_pc_i),
        .exc_cause   (exc_cause_i),
        .addr_vld    (exc_addr_vld_i),
        .exc_addr    (exc_addr_i),
        .dbg_pc      (dbg_pc_i),
        .dbg_cause   (dbg_cause_i),
        .old_status  (status_q),
        .cause_q     (cause_o),
        .vaddr_q     (vaddr_o),
        .epc1_q      (epc1_o),
        .depc_q      (depc_o),
        .dbg_cause_q (dbg_cause_o),
        .dbg_epc_q   (dbg_epc_o),
        .dbg_eps_q   (dbg_eps_o)
    );

    // state register: kind of dispatch taken at the last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs; user-mode bit cannot change on a take edge
    always_comb begin
        unique case (state_q)
            DS_IDLE:   vec = VEC_NONE;
            DS_SYNC:   vec = status_q[UM_BIT] ? VEC_USER : VEC_KERNEL;
            DS_DOUBLE: vec = VEC_DOUBLE;
            DS_DEBUG:  vec = VEC_DEBUG;
        endcase
    end

    assign take_o   = (state_q != DS_IDLE);
    assign vector_o = vec;
    assign status_o = status_q;
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
    import exc_dispatch_pkg::*;
#(
    parameter int DBG_LEVEL = 3,
    parameter int ADDR_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_req_i,
    input logic              dbg_req_i,
    input logic [ADDR_W-1:0] exc_pc_i,
    input logic              take_o,
    input logic [2:0]        vector_o,
    input logic [7:0]        status_o,
    input logic [ADDR_W-1:0] epc1_o
);
    assert_take_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(exc_req_i || dbg_req_i));

    assert_take_sets_excm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> status_o[EXCM_BIT]);

    assert_double_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_i && status_o[EXCM_BIT]) |=> (vector_o == 3'd3));

    assert_kernel_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_i && !status_o[EXCM_BIT] && !status_o[UM_BIT])
        |=> (vector_o == 3'd1 && epc1_o == $past(exc_pc_i)));

    assert_debug_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req_i && !exc_req_i && status_o[IL_LSB +: IL_W] >= IL_W'(DBG_LEVEL))
        |=> !take_o);

    assert_fault_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_i && dbg_req_i) |=> (vector_o != 3'd4));

    assert_debug_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req_i && !exc_req_i && status_o[IL_LSB +: IL_W] < IL_W'(DBG_LEVEL))
        |=> (status_o[IL_LSB +: IL_W] == IL_W'(DBG_LEVEL) && vector_o == 3'd4));
endmodule

bind exc_dispatch exc_dispatch_chk #(
    .DBG_LEVEL (DBG_LEVEL),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_req_i (exc_req_i),
    .dbg_req_i (dbg_req_i),
    .exc_pc_i  (exc_pc_i),
    .take_o    (take_o),
    .vector_o  (vector_o),
    .status_o  (status_o),
    .epc1_o    (epc1_o)
);

// File: tb/exc_dispatch_bench.sv
`timescale 1ns/1ps
module exc_dispatch_bench;
    localparam int L = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [5:0]  exc_cause = '0;
    logic [31:0] exc_pc = '0;
    logic        av = 1'b0;
    logic [31:0] exc_addr = '0;
    logic        dbg_req = 1'b0;
    logic [5:0]  dbg_cause = '0;
    logic [31:0] dbg_pc = '0;
    logic        st_wr = 1'b0;
    logic [7:0]  st_wdata = '0;

    logic        take   [2];
    logic [2:0]  vec    [2];
    logic [7:0]  status [2];
    logic [5:0]  cause  [2];
    logic [31:0] vaddr  [2];
    logic [31:0] epc1   [2];
    logic [31:0] depc   [2];
    logic [5:0]  dcause [2];
    logic [31:0] depcl  [2];
    logic [7:0]  depsl  [2];

    always #2.5 clk = ~clk;

    exc_dispatch #(.DBG_LEVEL(L), .HAS_DEPC(1'b1)) u_exc_dispatch (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_cause_i(exc_cause),
        .exc_pc_i(exc_pc), .exc_addr_vld_i(av), .exc_addr_i(exc_addr),
        .dbg_req_i(dbg_req), .dbg_cause_i(dbg_cause), .dbg_pc_i(dbg_pc),
        .st_wr_i(st_wr), .st_wdata_i(st_wdata),
        .take_o(take[0]), .vector_o(vec[0]), .status_o(status[0]), .cause_o(cause[0]),
        .vaddr_o(vaddr[0]), .epc1_o(epc1[0]), .depc_o(depc[0]),
        .dbg_cause_o(dcause[0]), .dbg_epc_o(depcl[0]), .dbg_eps_o(depsl[0]));

    exc_dispatch #(.DBG_LEVEL(L), .HAS_DEPC(1'b0)) u_exc_dispatch_nodepc (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_cause_i(exc_cause),
        .exc_pc_i(exc_pc), .exc_addr_vld_i(av), .exc_addr_i(exc_addr),
        .dbg_req_i(dbg_req), .dbg_cause_i(dbg_cause), .dbg_pc_i(dbg_pc),
        .st_wr_i(st_wr), .st_wdata_i(st_wdata),
        .take_o(take[1]), .vector_o(vec[1]), .status_o(status[1]), .cause_o(cause[1]),
        .vaddr_o(vaddr[1]), .epc1_o(epc1[1]), .depc_o(depc[1]),
        .dbg_cause_o(dcause[1]), .dbg_epc_o(depcl[1]), .dbg_eps_o(depsl[1]));

    // reference model state, per configuration (0: double PC present, 1: absent)
    int unsigned m_take[2], m_vec[2], m_ps[2], m_cause[2], m_vaddr[2];
    int unsigned m_epc1[2], m_depc[2], m_dcause[2], m_depcl[2], m_depsl[2];
    int total = 0;
    int bad = 0;
    bit checking = 1'b0;
    string cur_tag = "R1";
    string seen_tag = "R1";

    always @(posedge clk) begin
        seen_tag = cur_tag;
        for (int c = 0; c < 2; c++) begin
            if (!rst_n) begin
                m_take[c] = 0; m_vec[c] = 0; m_ps[c] = 0; m_cause[c] = 0;
                m_vaddr[c] = 0; m_epc1[c] = 0; m_depc[c] = 0; m_dcause[c] = 0;
                m_depcl[c] = 0; m_depsl[c] = 0;
            end else begin
                m_take[c] = 0;
                m_vec[c] = 0;
                if (exc_req) begin
                    if ((m_ps[c] & 32'h10) != 0) begin
                        m_vec[c] = 3;
                        if (c == 0) m_depc[c] = exc_pc;
                        else        m_epc1[c] = exc_pc;
                    end else begin
                        m_epc1[c] = exc_pc;
                        m_vec[c] = ((m_ps[c] & 32'h20) != 0) ? 2 : 1;
                    end
                    m_cause[c] = exc_cause;
                    if (av) m_vaddr[c] = exc_addr;
                    m_ps[c] = m_ps[c] | 32'h10;
                    m_take[c] = 1;
                end else if (dbg_req && (m_ps[c] % 16) < L) begin
                    m_dcause[c] = dbg_cause;
                    m_depcl[c] = dbg_pc;
                    m_depsl[c] = m_ps[c];
                    m_ps[c] = (m_ps[c] & 32'hF0) | L | 32'h10;
                    m_vec[c] = 4;
                    m_take[c] = 1;
                end else if (st_wr) begin
                    m_ps[c] = st_wdata;
                end
            end
        end
    end

    task automatic chk(input string tag, input string what, input int unsigned act,
                       input int unsigned exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare every output of both instances on every falling edge
    always @(negedge clk) begin
        if (checking) begin
            for (int c = 0; c < 2; c++) begin
                chk(seen_tag, "take",    take[c],   m_take[c]);
                chk(seen_tag, "vector",  vec[c],    m_vec[c]);
                chk(seen_tag, "status",  status[c], m_ps[c]);
                chk(seen_tag, "cause",   cause[c],  m_cause[c]);
                chk(seen_tag, "vaddr",   vaddr[c],  m_vaddr[c]);
                chk(seen_tag, "epc1",    epc1[c],   m_epc1[c]);
                chk(seen_tag, "depc",    depc[c],   m_depc[c]);
                chk(seen_tag, "dcause",  dcause[c], m_dcause[c]);
                chk(seen_tag, "dbg_epc", depcl[c],  m_depcl[c]);
                chk(seen_tag, "dbg_eps", depsl[c],  m_depsl[c]);
            end
        end
    end

    task automatic step(input string tag, input bit e, input int unsigned ca,
                        input int unsigned pc, input bit a, input int unsigned ad,
                        input bit d, input int unsigned dc, input int unsigned dp,
                        input bit w, input int unsigned wd);
        @(posedge clk);
        #1;
        cur_tag = tag;
        exc_req = e; exc_cause = 6'(ca); exc_pc = pc; av = a; exc_addr = ad;
        dbg_req = d; dbg_cause = 6'(dc); dbg_pc = dp; st_wr = w; st_wdata = 8'(wd);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(5 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: explicit reset state
        chk("R1", "take after reset", take[0], 0);
        chk("R1", "status after reset", status[0], 0);
        chk("R1", "vector after reset", vec[1], 0);
        checking = 1'b1;
        idle("R1");
        // R2 kernel entry with address
        step("R2", 1, 5, 32'h100, 1, 32'hA000, 0, 0, 0, 0, 0);
        idle("R11");
        // R4 double exception: configurations diverge
        step("R4", 1, 7, 32'h200, 0, 0, 0, 0, 0, 0, 0);
        idle("R4");
        // R10 write user mode, exception mode clear
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h20);
        // R3 user entry, R6 no address
        step("R3", 1, 9, 32'h300, 0, 32'hDEAD, 0, 0, 0, 0, 0);
        idle("R6");
        // R10 write discarded when a fault is taken in the same cycle
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h00);
        step("R10", 1, 2, 32'h400, 1, 32'hB000, 0, 0, 0, 1, 32'h2F);
        idle("R5");
        // R7 debug taken at level 1 and at boundary level L-1
        step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h21);
        step("R7", 0, 0, 0, 0, 0, 1, 6'h11, 32'h500, 0, 0);
        idle("R7");
        step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, L - 1);
        step("R7", 0, 0, 0, 0, 0, 1, 6'h05, 32'h540, 0, 0);
        // R8 now at level L: ignored; then at level 7
        step("R8", 0, 0, 0, 0, 0, 1, 6'h22, 32'h600, 0, 0);
        idle("R8");
        step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h07);
        step("R8", 0, 0, 0, 0, 0, 1, 6'h23, 32'h680, 0, 0);
        idle("R8");
        // R9 simultaneous requests
        step("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h00);
        step("R9", 1, 3, 32'h700, 1, 32'hC000, 1, 6'h01, 32'h780, 0, 0);
        idle("R9");
        // R11 back-to-back faults, then quiet cycles
        step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h00);
        step("R11", 1, 4, 32'h800, 0, 0, 0, 0, 0, 0, 0);
        step("R11", 1, 6, 32'h840, 1, 32'hD000, 0, 0, 0, 0, 0);
        idle("R11");
        idle("R11");
        // R5 fault in user mode with level bits set keeps other bits
        step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hE2);
        step("R5", 1, 8, 32'h900, 0, 0, 0, 0, 0, 0, 0);
        idle("R5");
        idle("R5");
        @(negedge clk);
        checking = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule